// File: doc/BRIEF.md
# Firmware Image Update Sequencer

This block runs the host side of a chunked firmware update to a controller. A single start pulse launches the whole exchange. The block first sends a ready command and zeroes the three shared mailbox words. It then has an external copy engine place an image header in a staging window, sends a go command and follows the controller's replies. Those replies arrive as 32-bit status words made of four ASCII characters plus a controller flag word.

The image body moves in two equal halves through the same staging window. A driver-flag word is set to 1 after the low half and cleared to 0 after the high half, so it swings between the two values from one half to the next. After each half the block waits for the controller flag to change. If the controller asks for the low half again, the block repeats the low/high cycle, up to a fixed number of retries. Each status match is followed by a settle delay of a set number of cycles. Every wait is guarded by a watchdog, so a controller that stops responding ends the run with a timeout result instead of a hang.

Top module: `fwup_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `done_o`, `cmd_valid_o`, `mb_wr_o` and `cpy_req_o` are all 0.
- R2: After `start_i`, the block issues these actions in this order:
  - command word 0x10FE;
  - zero writes to mailbox word 0 (status), word 1 (controller flag) and word 2 (driver flag);
  - a copy request with source 0 and length HDR_BYTES (2048);
  - command word 0x20FE.
- R3: At most one of `cmd_valid_o`, `mb_wr_o` and `cpy_req_o` is high in any cycle. A copy request holds its source and length until the cycle `cpy_done_i` is seen, and every command word is 0x10FE or 0x20FE.
- R4: After the go command, the block waits for the controller flag to equal 1 and then for the status to equal 0x54784C4F (low request). It then waits at least SETTLE_CYC cycles and checks the status again. It then requests a copy with source HDR_BYTES and length HALF_BYTES (131072) and writes 1 to word 2.
- R5: After the low half, the block waits for the controller flag to differ from 1. If the status is then 0x4241444E (bad storage), the run ends and no high half is copied.
- R6: Otherwise the block waits for status 0x54784849 (high request), waits the settle delay and checks again. It then copies from source HDR_BYTES+HALF_BYTES with length HALF_BYTES, writes 0 to word 2 and waits for the controller flag to become nonzero.
- R7: After the high half, the run behaves as follows:
  - bad storage ends the run;
  - a low request starts a retry, which copies the low half again without a fresh settle delay;
  - any other status ends the run.
- R8: The retry counter increments on each re-request, and the run stops once it exceeds MAX_RETRY. A controller that always re-requests therefore receives MAX_RETRY+1 low halves and MAX_RETRY+1 high halves, and the result is failure.
- R9: `done_o` is a one-cycle pulse. `result_o` is 0 (success) only if the status read in the final evaluation equals 0x444F4E45. Otherwise it is 1 (failure).
- R10: If any wait or copy state lasts longer than WDOG_CYC cycles, the run ends with `result_o` = 2 (timeout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a run when the block is idle |
| done_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | 2 | 0 success, 1 failure, 2 timeout |
| cmd_valid_o | output | 1 | Command word valid for one cycle |
| cmd_word_o | output | 16 | Command word (ready or go) |
| cpy_req_o | output | 1 | Copy request, held until done |
| cpy_src_o | output | ADDR_W | Image source offset of the copy |
| cpy_len_o | output | ADDR_W | Copy length in bytes |
| cpy_done_i | input | 1 | Copy engine finished |
| mb_wr_o | output | 1 | Mailbox word write strobe |
| mb_sel_o | output | 2 | Mailbox word: 0 status, 1 controller flag, 2 driver flag |
| mb_wdata_o | output | 32 | Mailbox write data |
| mb_status_i | input | 32 | Current mailbox status word |
| mb_cflag_i | input | 32 | Current controller flag word |

## Verification
The assertions rely on two properties of the environment:
- the copy engine raises `cpy_done_i` only while a request is pending, and holds it for exactly one cycle;
- the mailbox status word does not change between the last evaluation and the end pulse.

The bench's controller model respects both. It updates status and flag only in response to the block's own go command and driver-flag writes. It leaves them unchanged during the evaluation cycle. Its copy engine answers each request once, after a fixed latency.

// File: rtl/fwup_pkg.sv
package fwup_pkg;

    localparam int CPY_W = 32;

    localparam logic [15:0] CMD_READY = 16'h10FE;
    localparam logic [15:0] CMD_GO    = 16'h20FE;

    localparam logic [31:0] ST_DONE = 32'h444F4E45;
    localparam logic [31:0] ST_BADN = 32'h4241444E;
    localparam logic [31:0] ST_HIGH = 32'h54784849;
    localparam logic [31:0] ST_LOW  = 32'h54784C4F;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_FAIL    = 2'd1,
        RES_TIMEOUT = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        MB_STATUS = 2'd0,
        MB_CFLAG  = 2'd1,
        MB_DFLAG  = 2'd2
    } mb_sel_e;

    typedef enum logic [4:0] {
        S_IDLE, S_RDY, S_CLR_ST, S_CLR_CF, S_CLR_DF, S_CPY_HDR, S_GO,
        S_W_CF1, S_W_LOW, S_SET_L, S_CHK_L, S_CPY_LO, S_DF1, S_W_CFN1,
        S_W_HIGH, S_SET_H, S_CHK_H, S_CPY_HI, S_DF0, S_W_CFNZ, S_EVAL, S_FIN
    } st_e;

    typedef struct packed {
        logic             req;
        logic [CPY_W-1:0] src;
        logic [CPY_W-1:0] len;
    } cpy_t;

    typedef struct packed {
        logic        wr;
        mb_sel_e     sel;
        logic [31:0] data;
    } mbw_t;

    function automatic logic st_is_copy(st_e s);
        return (s == S_CPY_HDR) || (s == S_CPY_LO) || (s == S_CPY_HI);
    endfunction

    function automatic logic st_is_wait(st_e s);
        return st_is_copy(s) || (s == S_W_CF1) || (s == S_W_LOW) ||
               (s == S_W_CFN1) || (s == S_W_HIGH) || (s == S_W_CFNZ);
    endfunction

    function automatic logic st_is_settle(st_e s);
        return (s == S_SET_L) || (s == S_SET_H);
    endfunction

endpackage

// File: rtl/fwup_tmr.sv
module fwup_tmr #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    output logic exp_o
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign exp_o = (cnt_q == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (en_i && !exp_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fwup_fsm.sv
module fwup_fsm
    import fwup_pkg::*;
#(
    parameter int MAX_RETRY = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] status_i,
    input  logic [31:0] cflag_i,
    input  logic        cpy_done_i,
    input  logic        settle_exp_i,
    input  logic        wdog_exp_i,
    output st_e         state_o,
    output logic        tmr_clr_o,
    output res_e        result_o
);
    localparam int RW = $clog2(MAX_RETRY + 2);

    st_e           state_q, state_d;
    res_e          res_q, res_d;
    logic [RW-1:0] retry_q, retry_d;

    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        retry_d = retry_q;
        unique case (state_q)
            S_IDLE:    if (start_i) begin
                           state_d = S_RDY;
                           retry_d = '0;
                       end
            S_RDY:     state_d = S_CLR_ST;
            S_CLR_ST:  state_d = S_CLR_CF;
            S_CLR_CF:  state_d = S_CLR_DF;
            S_CLR_DF:  state_d = S_CPY_HDR;
            S_CPY_HDR: if (cpy_done_i) state_d = S_GO;
            S_GO:      state_d = S_W_CF1;
            S_W_CF1:   if (cflag_i == 32'd1) state_d = S_W_LOW;
            S_W_LOW:   if (status_i == ST_LOW) state_d = S_SET_L;
            S_SET_L:   if (settle_exp_i) state_d = S_CHK_L;
            S_CHK_L:   state_d = ((retry_q > RW'(MAX_RETRY)) || (status_i != ST_LOW))
                                 ? S_EVAL : S_CPY_LO;
            S_CPY_LO:  if (cpy_done_i) state_d = S_DF1;
            S_DF1:     state_d = S_W_CFN1;
            S_W_CFN1:  if (cflag_i != 32'd1)
                           state_d = (status_i == ST_BADN) ? S_EVAL : S_W_HIGH;
            S_W_HIGH:  if (status_i == ST_HIGH) state_d = S_SET_H;
            S_SET_H:   if (settle_exp_i) state_d = S_CHK_H;
            S_CHK_H:   state_d = (status_i == ST_HIGH) ? S_CPY_HI : S_EVAL;
            S_CPY_HI:  if (cpy_done_i) state_d = S_DF0;
            S_DF0:     state_d = S_W_CFNZ;
            S_W_CFNZ:  if (cflag_i != 32'd0) begin
                           if (status_i == ST_LOW) begin
                               retry_d = retry_q + 1'b1;
                               state_d = S_CHK_L;
                           end else begin
                               state_d = S_EVAL;
                           end
                       end
            S_EVAL:    begin
                           res_d   = (status_i == ST_DONE) ? RES_OK : RES_FAIL;
                           state_d = S_FIN;
                       end
            S_FIN:     state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
        if (st_is_wait(state_q) && wdog_exp_i && (state_d == state_q)) begin
            res_d   = RES_TIMEOUT;
            state_d = S_FIN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            res_q   <= RES_OK;
            retry_q <= '0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
            retry_q <= retry_d;
        end
    end

    assign state_o   = state_q;
    assign tmr_clr_o = (state_d != state_q);
    assign result_o  = res_q;
endmodule

// File: rtl/fwup_seq.sv
module fwup_seq
    import fwup_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int HDR_BYTES  = 2048,
    parameter int HALF_BYTES = 131072,
    parameter int SETTLE_CYC = 1250000,
    parameter int WDOG_CYC   = 16777216,
    parameter int MAX_RETRY  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic              cmd_valid_o,
    output logic [15:0]       cmd_word_o,
    output logic              cpy_req_o,
    output logic [ADDR_W-1:0] cpy_src_o,
    output logic [ADDR_W-1:0] cpy_len_o,
    input  logic              cpy_done_i,
    output logic              mb_wr_o,
    output logic [1:0]        mb_sel_o,
    output logic [31:0]       mb_wdata_o,
    input  logic [31:0]       mb_status_i,
    input  logic [31:0]       mb_cflag_i
);
    localparam logic [CPY_W-1:0] LO_SRC = CPY_W'(HDR_BYTES);
    localparam logic [CPY_W-1:0] HI_SRC = CPY_W'(HDR_BYTES + HALF_BYTES);

    st_e  state;
    res_e res;
    logic tmr_clr, settle_exp, wdog_exp;
    cpy_t cpy;
    mbw_t mbw;

    fwup_fsm #(.MAX_RETRY(MAX_RETRY)) u_fsm (
        .clk(clk), .rst(rst), .start_i(start_i),
        .status_i(mb_status_i), .cflag_i(mb_cflag_i), .cpy_done_i(cpy_done_i),
        .settle_exp_i(settle_exp), .wdog_exp_i(wdog_exp),
        .state_o(state), .tmr_clr_o(tmr_clr), .result_o(res)
    );

    fwup_tmr #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk(clk), .rst(rst), .clr_i(tmr_clr),
        .en_i(st_is_settle(state)), .exp_o(settle_exp)
    );

    fwup_tmr #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk(clk), .rst(rst), .clr_i(tmr_clr),
        .en_i(st_is_wait(state)), .exp_o(wdog_exp)
    );

    always_comb begin
        cpy = '0;
        cpy.req = st_is_copy(state);
        unique case (state)
            S_CPY_HDR: begin cpy.src = '0;     cpy.len = CPY_W'(HDR_BYTES);  end
            S_CPY_LO:  begin cpy.src = LO_SRC; cpy.len = CPY_W'(HALF_BYTES); end
            S_CPY_HI:  begin cpy.src = HI_SRC; cpy.len = CPY_W'(HALF_BYTES); end
            default:   ;
        endcase
    end

    always_comb begin
        mbw = '{wr: 1'b0, sel: MB_STATUS, data: 32'd0};
        unique case (state)
            S_CLR_ST: mbw = '{wr: 1'b1, sel: MB_STATUS, data: 32'd0};
            S_CLR_CF: mbw = '{wr: 1'b1, sel: MB_CFLAG,  data: 32'd0};
            S_CLR_DF: mbw = '{wr: 1'b1, sel: MB_DFLAG,  data: 32'd0};
            S_DF1:    mbw = '{wr: 1'b1, sel: MB_DFLAG,  data: 32'd1};
            S_DF0:    mbw = '{wr: 1'b1, sel: MB_DFLAG,  data: 32'd0};
            default:  ;
        endcase
    end

    assign cmd_valid_o = (state == S_RDY) || (state == S_GO);
    assign cmd_word_o  = (state == S_GO) ? CMD_GO : CMD_READY;
    assign cpy_req_o   = cpy.req;
    assign cpy_src_o   = ADDR_W'(cpy.src);
    assign cpy_len_o   = ADDR_W'(cpy.len);
    assign mb_wr_o     = mbw.wr;
    assign mb_sel_o    = mbw.sel;
    assign mb_wdata_o  = mbw.data;
    assign done_o      = (state == S_FIN);
    assign result_o    = res;
endmodule

// File: rtl/fwup_seq_chk.sv
module fwup_seq_chk
    import fwup_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              done_o,
    input logic [1:0]        result_o,
    input logic              cmd_valid_o,
    input logic [15:0]       cmd_word_o,
    input logic              cpy_req_o,
    input logic [ADDR_W-1:0] cpy_src_o,
    input logic              cpy_done_i,
    input logic              mb_wr_o,
    input logic [31:0]       mb_status_i
);
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid_o, mb_wr_o, cpy_req_o}));                            // R3

    AST_COPY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cpy_req_o && !cpy_done_i) |=> (cpy_req_o && $stable(cpy_src_o)));       // R3

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (cmd_word_o == CMD_READY || cmd_word_o == CMD_GO));      // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                                     // R9

    AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == 2'd0) |-> ($past(mb_status_i) == ST_DONE));       // R9
endmodule

bind fwup_seq fwup_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .done_o(done_o), .result_o(result_o),
    .cmd_valid_o(cmd_valid_o), .cmd_word_o(cmd_word_o),
    .cpy_req_o(cpy_req_o), .cpy_src_o(cpy_src_o), .cpy_done_i(cpy_done_i),
    .mb_wr_o(mb_wr_o), .mb_status_i(mb_status_i)
);

// File: tb/fwup_seq_tb_top.sv
module fwup_seq_tb_top;
    import fwup_pkg::*;

    localparam int SETTLE = 8;
    localparam int WDOG   = 200;
    localparam int MAXR   = 5;
    localparam int M_OK = 0, M_BADLO = 1, M_BADHI = 2, M_RETRY1 = 3, M_RETRYALL = 4, M_TMO = 5;

    typedef struct packed {
        logic [1:0] res;
        logic [7:0] lo;
        logic [7:0] hi;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic done_o, cmd_valid_o, cpy_req_o, mb_wr_o;
    logic [1:0] result_o, mb_sel_o;
    logic [15:0] cmd_word_o;
    logic [31:0] cpy_src_o, cpy_len_o, mb_wdata_o;
    logic cpy_done_i = 1'b0;
    logic [31:0] status = 32'd0, cflag = 32'd0, dflag = 32'd0;

    int checks = 0, fails = 0, cyc = 0, conflicts = 0;
    int mode = M_OK;
    bit go_seen = 0, rec = 0, cbusy = 0, finished = 0;
    int ccnt = 0, retries = 0, lo_cnt = 0, hi_cnt = 0, go_cyc = 0, lo_cyc = 0;
    int evq[$];
    exp_t exp_q[$];

    always #4 clk = ~clk;

    fwup_seq #(.SETTLE_CYC(SETTLE), .WDOG_CYC(WDOG), .MAX_RETRY(MAXR)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o), .result_o(result_o),
        .cmd_valid_o(cmd_valid_o), .cmd_word_o(cmd_word_o),
        .cpy_req_o(cpy_req_o), .cpy_src_o(cpy_src_o), .cpy_len_o(cpy_len_o),
        .cpy_done_i(cpy_done_i), .mb_wr_o(mb_wr_o), .mb_sel_o(mb_sel_o),
        .mb_wdata_o(mb_wdata_o), .mb_status_i(status), .mb_cflag_i(cflag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // controller mailbox model
    always @(negedge clk) begin
        if (rst) begin
            status <= 0; cflag <= 0; dflag <= 0; go_seen <= 0; retries <= 0;
        end else begin
            if (cmd_valid_o && cmd_word_o == CMD_READY) begin
                go_seen <= 0; retries <= 0;
            end
            if (cmd_valid_o && cmd_word_o == CMD_GO) begin
                go_seen <= 1; go_cyc <= cyc;
                if (mode != M_TMO) begin status <= ST_LOW; cflag <= 1; end
            end
            if (mb_wr_o) begin
                if (!go_seen) begin
                    case (mb_sel_o)
                        2'd0: status <= mb_wdata_o;
                        2'd1: cflag <= mb_wdata_o;
                        default: dflag <= mb_wdata_o;
                    endcase
                end else if (mb_sel_o == 2'd2 && mb_wdata_o == 32'd1) begin
                    cflag <= 0;
                    status <= (mode == M_BADLO) ? ST_BADN : ST_HIGH;
                end else if (mb_sel_o == 2'd2) begin
                    cflag <= 1;
                    if (mode == M_BADHI) status <= ST_BADN;
                    else if (mode == M_RETRYALL || (mode == M_RETRY1 && retries == 0)) begin
                        status <= ST_LOW; retries <= retries + 1;
                    end else status <= ST_DONE;
                end
            end
        end
    end

    // copy engine model
    always @(negedge clk) begin
        if (cpy_done_i) cpy_done_i <= 1'b0;
        if (cmd_valid_o && cmd_word_o == CMD_READY) begin lo_cnt <= 0; hi_cnt <= 0; end
        if (!cpy_req_o) cbusy <= 0;
        else if (!cbusy) begin
            cbusy <= 1; ccnt <= 3;
            if (cpy_src_o == 32'd0)
                chk(cpy_len_o == 32'd2048, "R2 header length", cpy_len_o, 32'd2048);
            else if (cpy_src_o == 32'h800) begin
                chk(cpy_len_o == 32'h20000, "R4 low half length", cpy_len_o, 32'h20000);
                if (lo_cnt == 0) lo_cyc <= cyc;
                lo_cnt <= lo_cnt + 1;
            end else begin
                chk(cpy_src_o == 32'h20800, "R6 high half source", cpy_src_o, 32'h20800);
                chk(cpy_len_o == 32'h20000, "R6 high half length", cpy_len_o, 32'h20000);
                hi_cnt <= hi_cnt + 1;
            end
        end else if (ccnt != 0) begin
            ccnt <= ccnt - 1;
            if (ccnt == 1) cpy_done_i <= 1'b1;
        end
    end

    // action order recorder and exclusivity counter
    always @(negedge clk) begin
        if (!rst) begin
            if (int'(cmd_valid_o) + int'(mb_wr_o) + int'(cpy_req_o) > 1) conflicts <= conflicts + 1;
            if (rec && evq.size() < 6) begin
                if (cmd_valid_o) evq.push_back(cmd_word_o == CMD_READY ? 1 : 6);
                if (mb_wr_o && !go_seen) evq.push_back(2 + int'(mb_sel_o));
                if (cpy_req_o && !cbusy && cpy_src_o == 32'd0) evq.push_back(5);
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (exp_q.size() == 0) chk(0, "R9 unexpected done", 1, 0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(result_o == e.res, "R9/R10 result", 32'(result_o), 32'(e.res));
                chk(lo_cnt == int'(e.lo), "R5/R7/R8 low copies", lo_cnt, 32'(e.lo));
                chk(hi_cnt == int'(e.hi), "R5/R7/R8 high copies", hi_cnt, 32'(e.hi));
            end
        end
    end

    task automatic run_case(input int m, input logic [1:0] res, input int lo, input int hi);
        mode = m;
        exp_q.push_back('{res: res, lo: 8'(lo), hi: 8'(hi)});
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done_o && !cmd_valid_o && !mb_wr_o && !cpy_req_o, "R1 quiet in reset",
            {done_o, cmd_valid_o, mb_wr_o, cpy_req_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && !cmd_valid_o && !mb_wr_o && !cpy_req_o, "R1 quiet after reset",
            {done_o, cmd_valid_o, mb_wr_o, cpy_req_o}, 0);

        rec = 1;
        run_case(M_OK, 2'd0, 1, 1);                  // R4 R6 R9 success path
        rec = 0;
        chk(evq.size() == 6, "R2 action count", evq.size(), 6);
        for (int i = 0; i < 6 && i < evq.size(); i++)
            chk(evq[i] == i + 1, "R2 action order", evq[i], i + 1);
        chk(lo_cyc - go_cyc >= SETTLE, "R4 settle delay", lo_cyc - go_cyc, SETTLE);

        run_case(M_BADLO, 2'd1, 1, 0);               // R5
        run_case(M_BADHI, 2'd1, 1, 1);               // R7 bad after high
        run_case(M_RETRY1, 2'd0, 2, 2);              // R7 one retry
        run_case(M_RETRYALL, 2'd1, MAXR + 1, MAXR + 1); // R8 cap
        run_case(M_TMO, 2'd2, 0, 0);                 // R10
        run_case(M_OK, 2'd0, 1, 1);                  // R9 recovers after timeout

        chk(conflicts == 0, "R3 exclusive actions", conflicts, 0);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        summary();
    end
endmodule